// File: doc/BRIEF.md
# Program Address Unit with Interrupt Call and Loop Counters

This block holds the next instruction fetch address of a small 16-bit core. Every accepted fetch advances the address by one, and a register write to the pointer redirects program flow to the written address. A small two-state machine watches an interrupt-pending input. When an interrupt is pending and enabled, the block makes a hardware call. It presents the current pointer as the return address to an external stack, and in the same cycle it loads a fixed vector address.

The block also holds two 16-bit loop counters. Each one steps down on its own strobe and reports a zero flag, which the decoder uses as the condition for a counted loop branch. Software reads the pointer, the vector and the counters through a side-effect-free read port. The read-only vector register ignores writes. Instruction decode and the stack memory sit outside this block.

The interrupt state machine has two states. ST_RUN is the normal state, in which a call can be taken. ST_HELD follows a call and blocks further calls. The transitions are RUN->HELD (call taken), HELD->RUN (pending input low) and HELD->HELD (pending input still high).

Top module: `pcu_top`

## Requirements
- R1: After reset the fetch address is 8000h, both counters are 0000h, both zero flags are 1 and push_req is 0.
- R2: A fetch strobe without a pointer write or a call makes the fetch address one higher on the next cycle, wrapping from FFFFh to 0000h.
- R3: A write with select code 0 loads the pointer with the write data on the next cycle, and this takes priority over a fetch strobe in the same cycle.
- R4: rd_data combinationally returns the register named by rd_sel, using select codes 0 for the pointer, 1 for the vector (always 07FDh), 2 for counter 0 and 3 for counter 1. Reading changes no state.
- R5: A write with select code 1 (the vector) has no effect on any register.
- R6: In ST_RUN, when irq_pend and irq_en are high and no pointer write is present, push_req is 1 and push_addr equals the current fetch address in that cycle. On the next cycle the fetch address is 07FDh, and a fetch strobe in the call cycle is ignored.
- R7: No call is taken while irq_en is low, while in ST_HELD, or in a cycle that writes the pointer. A call therefore never lasts two consecutive cycles.
- R8: From ST_HELD the machine returns to ST_RUN in the cycle after the first clock edge at which irq_pend is low. A new pending, enabled interrupt is then called again.
- R9: A decrement strobe on lc_dec[i] lowers counter i by one on the next cycle, wrapping from 0000h to FFFFh.
- R10: A write with select code 2+i loads counter i with the write data, taking priority over its decrement strobe.
- R11: lc_zero[i] is 1 exactly when counter i holds 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| fetch | input | 1 | Fetch strobe, one per fetched word |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write select: 0 pointer, 1 vector, 2 counter 0, 3 counter 1 |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read select, same codes as wr_sel |
| rd_data | output | 16 | Read data |
| irq_pend | input | 1 | Interrupt pending |
| irq_en | input | 1 | Interrupt enable |
| lc_dec | input | 2 | Per-counter decrement strobes |
| fetch_addr | output | 16 | Next fetch address (pointer) |
| lc_value | output | 32 | Counter values, counter i at bits [16i+15:16i] |
| lc_zero | output | 2 | Per-counter zero flags |
| push_req | output | 1 | Hardware call taken: push the return address |
| push_addr | output | 16 | Return address to push |

## Verification
The bench goes after the priority corners. If a pointer write lost to a fetch, the branch would land one word too far. If a call did not defer to a pointer write in the same cycle, the branch would be lost or the wrong return address would be pushed. It also holds irq_pend high across many cycles: a machine that did not park in ST_HELD would push on every cycle and trap itself at the vector. Further checks cover the pointer wrap at FFFFh, the counter wrap at 0000h, a write to the vector register that must not change any read value, and a counter write racing its own decrement.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HELD = 1'b1
    } pcu_state_e;

    localparam int SEL_PTR     = 0;
    localparam int SEL_VEC     = 1;
    localparam int SEL_LC_BASE = 2;

endpackage

// File: rtl/pcu_ip_ctl.sv
module pcu_ip_ctl
    import pcu_pkg::*;
#(
    parameter int            AW       = 16,
    parameter logic [AW-1:0] RESET_IP = 16'h8000,
    parameter logic [AW-1:0] VEC_ADDR = 16'h07FD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch,
    input  logic          wr_ip,
    input  logic [AW-1:0] wr_data,
    input  logic          irq_pend,
    input  logic          irq_en,
    output logic [AW-1:0] ip_q,
    output logic          push_req,
    output logic [AW-1:0] push_addr
);

    pcu_state_e    state_q;
    pcu_state_e    state_n;
    logic          call_take;
    logic [AW-1:0] ip_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_n;
        end
    end

    // transitions
    always_comb begin
        call_take = 1'b0;
        state_n   = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (irq_pend && irq_en && !wr_ip) begin
                    call_take = 1'b1;
                    state_n   = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!irq_pend) begin
                    state_n = ST_RUN;
                end
            end
            default: state_n = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        push_req  = call_take;
        push_addr = ip_q;
    end

    // pointer next value: call, then write, then fetch
    always_comb begin
        if (call_take) begin
            ip_n = VEC_ADDR;
        end else if (wr_ip) begin
            ip_n = wr_data;
        end else if (fetch) begin
            ip_n = ip_q + AW'(1);
        end else begin
            ip_n = ip_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip_q <= RESET_IP;
        end else begin
            ip_q <= ip_n;
        end
    end

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !wr_ip && !push_req) |=> (ip_q == $past(ip_q) + AW'(1)));

    a_r3_write_branch: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ip |=> (ip_q == $past(wr_data)));

    a_r6_call_vector: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> (ip_q == VEC_ADDR));

    a_r7_single_call: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> !push_req);

    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !irq_pend) |-> !push_req);

endmodule

// File: rtl/pcu_loop_ctr.sv
module pcu_loop_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end else if (dec) begin
            value <= value - W'(1);
        end
    end

    assign zero = (value == '0);

    a_r9_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !wr) |=> (value == $past(value) - W'(1)));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (value == $past(wdata)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !wr) |=> $stable(value));

endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            N_LC     = 2,
    parameter logic [AW-1:0] RESET_IP = 16'h8000,
    parameter logic [AW-1:0] VEC_ADDR = 16'h07FD,
    localparam int           SEL_W    = $clog2(N_LC + SEL_LC_BASE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [AW-1:0]      wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [AW-1:0]      rd_data,
    input  logic               irq_pend,
    input  logic               irq_en,
    input  logic [N_LC-1:0]    lc_dec,
    output logic [AW-1:0]      fetch_addr,
    output logic [N_LC*AW-1:0] lc_value,
    output logic [N_LC-1:0]    lc_zero,
    output logic               push_req,
    output logic [AW-1:0]      push_addr
);

    logic          wr_ip;
    logic [AW-1:0] ip_q;
    logic [AW-1:0] lc_arr [N_LC];

    assign wr_ip      = wr_en && (wr_sel == SEL_W'(SEL_PTR));
    assign fetch_addr = ip_q;

    pcu_ip_ctl #(
        .AW       (AW),
        .RESET_IP (RESET_IP),
        .VEC_ADDR (VEC_ADDR)
    ) u_ip (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch     (fetch),
        .wr_ip     (wr_ip),
        .wr_data   (wr_data),
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .ip_q      (ip_q),
        .push_req  (push_req),
        .push_addr (push_addr)
    );

    for (genvar i = 0; i < N_LC; i++) begin : g_lc
        logic wr_lc;
        assign wr_lc = wr_en && (wr_sel == SEL_W'(SEL_LC_BASE + i));

        pcu_loop_ctr #(
            .W (AW)
        ) u_lc (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_lc),
            .wdata (wr_data),
            .dec   (lc_dec[i]),
            .value (lc_arr[i]),
            .zero  (lc_zero[i])
        );

        assign lc_value[i*AW +: AW] = lc_arr[i];
    end

    // side-effect-free read mux; the vector is a constant
    always_comb begin
        rd_data = '0;
        if (rd_sel == SEL_W'(SEL_PTR)) begin
            rd_data = ip_q;
        end else if (rd_sel == SEL_W'(SEL_VEC)) begin
            rd_data = VEC_ADDR;
        end
        for (int k = 0; k < N_LC; k++) begin
            if (rd_sel == SEL_W'(SEL_LC_BASE + k)) begin
                rd_data = lc_arr[k];
            end
        end
    end

    // R4 / R5: reads and vector writes leave the pointer alone
    a_r5_vec_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(SEL_VEC) && !fetch && !push_req) |=> $stable(ip_q));

endmodule

// File: tb/pcu_top_tb.sv
`timescale 1ns/1ps
module pcu_top_tb;

    localparam logic [15:0] VEC = 16'h07FD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        irq_pend = 1'b0;
    logic        irq_en = 1'b0;
    logic [1:0]  lc_dec = '0;
    logic [15:0] fetch_addr;
    logic [31:0] lc_value;
    logic [1:0]  lc_zero;
    logic        push_req;
    logic [15:0] push_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] ip_m;
    logic [15:0] lc_m [2];
    bit          held_m;

    always #2.5 clk = ~clk;

    pcu_top u_dut (
        .clk(clk), .rst_n(rst_n), .fetch(fetch), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_pend(irq_pend),
        .irq_en(irq_en), .lc_dec(lc_dec), .fetch_addr(fetch_addr), .lc_value(lc_value),
        .lc_zero(lc_zero), .push_req(push_req), .push_addr(push_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit f_call(bit held, logic p, logic e, logic we, logic [1:0] sel);
        return !held && p && e && !(we && sel == 2'd0);
    endfunction

    function automatic logic [15:0] f_read(logic [1:0] s);
        case (s)
            2'd0:    return ip_m;
            2'd1:    return VEC;
            2'd2:    return lc_m[0];
            default: return lc_m[1];
        endcase
    endfunction

    task automatic check_state(input string tag);
        chk(fetch_addr == ip_m, tag, {16'h0, fetch_addr}, {16'h0, ip_m});
        for (int i = 0; i < 2; i++) begin
            chk(lc_value[i*16 +: 16] == lc_m[i], "R9", {16'h0, lc_value[i*16 +: 16]}, {16'h0, lc_m[i]});
            chk(lc_zero[i] == (lc_m[i] == 16'h0), "R11", {31'h0, lc_zero[i]}, {31'h0, lc_m[i] == 16'h0});
        end
    endtask

    // one cycle: drive at negedge, check combinational outputs, advance model, check state
    task automatic cyc(input logic f, input logic we, input logic [1:0] sel, input logic [15:0] d,
                       input logic p, input logic e, input logic [1:0] dc, input logic [1:0] rs,
                       input string tag);
        bit call;
        fetch = f; wr_en = we; wr_sel = sel; wr_data = d;
        irq_pend = p; irq_en = e; lc_dec = dc; rd_sel = rs;
        #1;
        call = f_call(held_m, p, e, we, sel);
        chk(push_req == call, "R7", {31'h0, push_req}, {31'h0, call});
        if (call) chk(push_addr == ip_m, "R6", {16'h0, push_addr}, {16'h0, ip_m});
        chk(rd_data == f_read(rs), "R4", {16'h0, rd_data}, {16'h0, f_read(rs)});
        if (call)                   ip_m = VEC;
        else if (we && sel == 2'd0) ip_m = d;
        else if (f)                 ip_m = ip_m + 16'd1;
        for (int i = 0; i < 2; i++) begin
            if (we && sel == 2'(2 + i)) lc_m[i] = d;
            else if (dc[i])             lc_m[i] = lc_m[i] - 16'd1;
        end
        if (call)             held_m = 1;
        else if (held_m && !p) held_m = 0;
        @(negedge clk);
        check_state(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        ip_m = 16'h8000; lc_m[0] = '0; lc_m[1] = '0; held_m = 0;
        #12;
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(fetch_addr == 16'h8000, "R1", {16'h0, fetch_addr}, 32'h8000);
        chk(lc_value == 32'h0, "R1", lc_value, 32'h0);
        chk(lc_zero == 2'b11, "R1", {30'h0, lc_zero}, 32'h3);
        chk(push_req == 1'b0, "R1", {31'h0, push_req}, 32'h0);

        // R2 fetch steps and wrap
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(1, 1, 0, 16'hFFFF, 0, 0, 0, 0, "R3");   // write wins over fetch
        cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");          // FFFF -> 0000
        // R5 vector write ignored, read shows 07FD
        cyc(0, 1, 1, 16'h1234, 0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, "R5");
        // R9 counter wrap, R10 write wins over decrement
        cyc(0, 0, 0, 0, 0, 0, 2'b01, 2, "R9");
        cyc(0, 1, 2, 16'h0002, 0, 0, 2'b01, 2, "R10");
        cyc(0, 1, 3, 16'h0001, 0, 0, 0, 3, "R10");
        cyc(0, 0, 0, 0, 0, 0, 2'b10, 3, "R11");
        // R6 call with fetch ignored
        cyc(1, 1, 0, 16'h4000, 0, 0, 0, 0, "R3");
        cyc(1, 0, 0, 0, 1, 1, 0, 0, "R6");
        // R7 held while pending high
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 1, 1, 0, 0, "R7");
        // R8 drop pend, recall
        cyc(1, 0, 0, 0, 0, 1, 0, 0, "R8");
        cyc(1, 1, 0, 16'h2222, 1, 1, 0, 0, "R7");   // write defers call
        cyc(0, 0, 0, 0, 1, 1, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, "R7");          // disabled

        for (int n = 0; n < 3000; n++) begin
            logic we;
            logic p;
            we = ($urandom % 8) == 0;
            p  = ($urandom % 6) == 0 ? ~irq_pend : irq_pend;
            cyc($urandom % 2, we, 2'($urandom), 16'($urandom), p, $urandom % 2,
                2'($urandom), 2'($urandom), "R2");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule